// File: doc/BRIEF.md
# Reset Cause Status Register

This block records which kind of event caused the most recent system reset. It has four single-cycle event inputs: power-on, external pin, brown-out and watchdog. Each event has its own sticky flag. Software reads all four flags through an 8-bit read path. It clears flags one at a time by writing zeros to the chosen bit positions. A power-on event has priority: it sets its own flag and wipes the other three.

The flag storage is not reset by the ordinary system reset. Its only initialisation is a dedicated asynchronous power-on input, so the recorded cause survives the very reset it describes. Software normally reads the register early after start-up and then clears it. The next reset then leaves exactly one fresh flag behind.

Top module: `rcs_status`

## Requirements
- R1: While `rst_pwr_n` is low, and afterwards until another event or write, `rd_data` reads 0x01 (power-on flag set, all others clear).
- R2: Bits 7 down to 4 of `rd_data` always read zero, whatever value is written.
- R3: The flag positions are: bit 0 power-on, bit 1 external, bit 2 brown-out, bit 3 watchdog. A pulse on `evt_ext`, `evt_bod` or `evt_wdt` sets its flag, and the flag is visible on `rd_data` from the clock edge that samples the pulse.
- R4: A pulse on `evt_por` sets bit 0 and clears bits 3 to 1 at the same edge.
- R5: When `evt_por` and any other event pulse arrive together, the result is 0x01.
- R6: A write (`wr_en` high) with a zero in bit position i (i = 0..3) clears flag i. A one in that position leaves the flag unchanged.
- R7: No write value can set a flag that is clear.
- R8: If a flag's own event and a write of zero to that bit arrive in the same cycle, the flag ends up set.
- R9: The power-on flag is cleared only by a write of zero to bit 0. External, brown-out and watchdog events leave it unchanged.
- R10: With no event and no write, all flags hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pwr_n | input | 1 | Asynchronous power-on initialisation of the flag storage, active low |
| evt_por | input | 1 | Power-on event pulse |
| evt_ext | input | 1 | External reset event pulse |
| evt_bod | input | 1 | Brown-out event pulse |
| evt_wdt | input | 1 | Watchdog reset event pulse |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; zero bits clear flags |
| rd_data | output | 8 | Current register value |

## Verification
The assertions assume that the event inputs and the write strobe are synchronous to `clk` and hold stable around its rising edge. They also assume that `rst_pwr_n` is released only once and never falls again during normal operation; all properties are disabled while it is low. The bench changes every input only on the falling clock edge and releases `rst_pwr_n` once at the start. It then sweeps every starting flag state against every combination of event pulses and every write-data nibble, with and without the write strobe.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
   localparam int unsigned RCS_REG_W   = 8;
   localparam int unsigned RCS_NUM_SRC = 4;
   // bit positions of the cause flags inside the register
   localparam int unsigned RCS_IDX_POR = 0;
   localparam int unsigned RCS_IDX_EXT = 1;
   localparam int unsigned RCS_IDX_BOD = 2;
   localparam int unsigned RCS_IDX_WDT = 3;
endpackage

// File: rtl/rcs_flag_cell.sv
module rcs_flag_cell #(
   parameter bit PRIMARY = 1'b0
) (
   input  logic clk,
   input  logic rst_pwr_n,
   input  logic set_evt,
   input  logic wipe_evt,
   input  logic wr_en,
   input  logic wr_bit,
   output logic flag_q
);
   localparam logic INIT_VAL = PRIMARY;

   logic sw_clear;
   logic flag_d;

   assign sw_clear = wr_en && !wr_bit;

   generate
      if (PRIMARY) begin : g_primary
         // power-on flag: set by power-on, cleared only by software
         always_comb begin
            if (set_evt || wipe_evt) flag_d = 1'b1;
            else if (sw_clear)       flag_d = 1'b0;
            else                     flag_d = flag_q;
         end

         AST_POR_SETS: assert property (@(posedge clk) disable iff (!rst_pwr_n)
            (set_evt || wipe_evt) |=> flag_q); // R4
         AST_POR_HOLDS: assert property (@(posedge clk) disable iff (!rst_pwr_n)
            (flag_q && !sw_clear) |=> flag_q); // R9
         AST_POR_WR_CLR: assert property (@(posedge clk) disable iff (!rst_pwr_n)
            (sw_clear && !set_evt && !wipe_evt) |=> !flag_q); // R6
      end else begin : g_secondary
         // secondary flag: power-on wipe beats own event beats software clear
         always_comb begin
            if (wipe_evt)      flag_d = 1'b0;
            else if (set_evt)  flag_d = 1'b1;
            else if (sw_clear) flag_d = 1'b0;
            else               flag_d = flag_q;
         end

         AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (!rst_pwr_n)
            wipe_evt |=> !flag_q); // R4
         AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_pwr_n)
            (set_evt && !wipe_evt) |=> flag_q); // R8
         AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_pwr_n)
            (sw_clear && !set_evt && !wipe_evt) |=> !flag_q); // R6
      end
   endgenerate

   AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_pwr_n)
      (!flag_q && !set_evt && !wipe_evt) |=> !flag_q); // R7

   always_ff @(posedge clk or negedge rst_pwr_n) begin
      if (!rst_pwr_n) flag_q <= INIT_VAL;
      else            flag_q <= flag_d;
   end
endmodule

// File: rtl/rcs_readback.sv
module rcs_readback #(
   parameter int unsigned REG_W   = 8,
   parameter int unsigned NUM_SRC = 4
) (
   input  logic [NUM_SRC-1:0] flags,
   output logic [REG_W-1:0]   rd_data
);
   localparam int unsigned PAD_W = REG_W - NUM_SRC;

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = {{PAD_W{1'b0}}, flags};
      end else begin : g_nopad
         assign rd_data = flags;
      end
   endgenerate
endmodule

// File: rtl/rcs_status.sv
module rcs_status
   import rcs_pkg::*;
#(
   parameter int unsigned REG_W   = RCS_REG_W,
   parameter int unsigned NUM_SRC = RCS_NUM_SRC
) (
   input  logic             clk,
   input  logic             rst_pwr_n,
   input  logic             evt_por,
   input  logic             evt_ext,
   input  logic             evt_bod,
   input  logic             evt_wdt,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data
);
   generate
      if (REG_W < NUM_SRC) begin : g_bad_width
         $error("rcs_status: REG_W must hold all cause flags");
      end
      if (NUM_SRC != 4) begin : g_bad_src
         $error("rcs_status: exactly four reset sources are mapped");
      end
   endgenerate

   logic [NUM_SRC-1:0] events;
   logic [NUM_SRC-1:0] flags;

   always_comb begin
      events = '0;
      events[RCS_IDX_POR] = evt_por;
      events[RCS_IDX_EXT] = evt_ext;
      events[RCS_IDX_BOD] = evt_bod;
      events[RCS_IDX_WDT] = evt_wdt;
   end

   generate
      for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_flag
         rcs_flag_cell #(
            .PRIMARY (gi == RCS_IDX_POR)
         ) i_cell (
            .clk       (clk),
            .rst_pwr_n (rst_pwr_n),
            .set_evt   (events[gi]),
            .wipe_evt  (evt_por),
            .wr_en     (wr_en),
            .wr_bit    (wr_data[gi]),
            .flag_q    (flags[gi])
         );
      end
   endgenerate

   rcs_readback #(
      .REG_W   (REG_W),
      .NUM_SRC (NUM_SRC)
   ) i_readback (
      .flags   (flags),
      .rd_data (rd_data)
   );

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_pwr_n)
      rd_data[REG_W-1:NUM_SRC] == '0); // R2
   AST_POR_ONLY: assert property (@(posedge clk) disable iff (!rst_pwr_n)
      evt_por |=> (rd_data == REG_W'(1))); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_pwr_n)
      (!wr_en && events == '0) |=> $stable(rd_data)); // R10
endmodule

// File: tb/test_rcs_status.sv
module test_rcs_status;
   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG_CYCLES = 150000;

   logic       clk = 1'b0;
   logic       rst_pwr_n = 1'b0;
   logic       evt_por = 1'b0, evt_ext = 1'b0, evt_bod = 1'b0, evt_wdt = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rcs_status i_rcs_status (
      .clk(clk), .rst_pwr_n(rst_pwr_n),
      .evt_por(evt_por), .evt_ext(evt_ext), .evt_bod(evt_bod), .evt_wdt(evt_wdt),
      .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
   );

   task automatic check(input string tag, input logic [7:0] exp);
      checks++;
      if (rd_data !== exp) begin
         errors++;
         $display("FAIL %s: rd_data=%02h expected=%02h", tag, rd_data, exp);
      end
   endtask

   // one clocked step: e = {wdt,bod,ext,por}; result readable after return
   task automatic step(input logic [3:0] e, input logic we, input logic [7:0] w);
      @(negedge clk);
      evt_por = e[0]; evt_ext = e[1]; evt_bod = e[2]; evt_wdt = e[3];
      wr_en = we; wr_data = w;
      @(negedge clk);
      evt_por = 1'b0; evt_ext = 1'b0; evt_bod = 1'b0; evt_wdt = 1'b0;
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   function automatic logic [3:0] model(input logic [3:0] s, input logic [3:0] e,
                                        input logic we, input logic [7:0] w);
      logic [3:0] r;
      if (e[0]) return 4'b0001;
      r = s;
      if (we) r = r & w[3:0];
      return r | e;
   endfunction

   function automatic string pick_tag(input logic [3:0] s, input logic [3:0] e,
                                      input logic we, input logic [7:0] w);
      if (e[0] && e[3:1] != 0) return "R5";
      if (e[0])                return "R4";
      if (we && (e & ~w[3:0]) != 0) return "R8";
      if (we && (~s & w[3:0]) != 0)  return "R7";
      if (we)                  return "R6";
      if (e != 0)              return "R3";
      return "R10";
   endfunction

   // drive the flags into state s from any state
   task automatic load_state(input logic [3:0] s);
      step(4'b0001, 1'b0, 8'h00);
      if (s[3:1] != 0) step({s[3:1], 1'b0}, 1'b0, 8'h00);
      if (!s[0]) step(4'b0000, 1'b1, 8'hFE);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG_CYCLES) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, actual=expired expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      #(CLK_PERIOD*2);
      check("R1 during power-on init", 8'h01);
      @(negedge clk);
      rst_pwr_n = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 after release", 8'h01);

      // R9: other events never clear the power-on flag
      step(4'b0010, 1'b0, 8'h00); check("R9 ext keeps por", 8'h03);
      step(4'b0100, 1'b0, 8'h00); check("R9 bod keeps por", 8'h07);
      step(4'b1000, 1'b0, 8'h00); check("R9 wdt keeps por", 8'h0F);
      step(4'b0000, 1'b1, 8'hF1); check("R6 selective clear", 8'h01);
      step(4'b0000, 1'b1, 8'hFE); check("R9 write zero clears por", 8'h00);
      step(4'b0000, 1'b1, 8'hFF); check("R7 write ones sets nothing", 8'h00);
      step(4'b0000, 1'b1, 8'hF0); check("R2 reserved stay zero", 8'h00);

      // near-exhaustive sweep: every state, event combo, write nibble
      for (int s = 0; s < 16; s++) begin
         for (int e = 0; e < 16; e++) begin
            for (int k = 0; k < 17; k++) begin
               logic       we;
               logic [7:0] w;
               logic [3:0] exp4;
               we = (k < 16);
               w  = {4'(k * 5 + 3), 4'(k)};
               load_state(4'(s));
               check("R3 state load", {4'h0, 4'(s)});
               step(4'(e), we, w);
               exp4 = model(4'(s), 4'(e), we, w);
               check(pick_tag(4'(s), 4'(e), we, w), {4'h0, exp4});
               if (rd_data[7:4] !== 4'h0) begin
                  errors++;
                  $display("FAIL R2: rd_data=%02h expected upper=0", rd_data);
               end
               checks++;
            end
         end
      end

      // R10: flags persist with no traffic
      load_state(4'b1010);
      repeat (5) @(negedge clk);
      check("R10 idle hold", 8'h0A);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule